// File: doc/BRIEF.md
# Root-Port Interrupt Message Queue

This block sits beside a PCIe root port and collects the interrupt traffic coming up from the link. It queues two kinds of event. A legacy line interrupt carries a 2-bit line number. An inbound memory write becomes an MSI when its 64-bit address matches a programmable target and its data value is a supported vector. Software reads the oldest entry through two read words. The first word packs a valid flag, the entry kind and the line number. The second word gives the MSI data of that same entry. A single pop strobe, which stands for a write to the first word, retires the entry.

Two pending flags, one for line interrupts and one for MSIs, feed the port's interrupt decode logic. Each is true while at least one entry of its kind is queued. If an event arrives when there is no room for it, the event is lost and a sticky overflow flag is raised.

Occupancy is tracked by a three-state controller:
- Q_EMPTY: nothing queued.
- Q_PARTIAL: some entries queued, some room left.
- Q_FULL: every slot used.

Its transitions are:
- FIRST_IN: Q_EMPTY to Q_PARTIAL, on any accepted event.
- LAST_OUT: Q_PARTIAL to Q_EMPTY, when the count reaches zero.
- FILL_UP: Q_PARTIAL to Q_FULL, when the count reaches the depth.
- MAKE_ROOM: Q_FULL to Q_PARTIAL, on a pop.

Any other cycle holds the state.

Top module: `rp_irq_msg_queue`

## Requirements
- R1: Bit 31 of `rd_word1` is 1 exactly when the queue holds at least one entry. When the queue is empty, the whole of `rd_word1` reads 0.
- R2: Bit 30 of `rd_word1` is 1 when the head entry is an MSI and 0 when it is a line interrupt.
- R3: For a line-interrupt head, bits 28:27 of `rd_word1` hold its line number (0 to 3). All other bits of `rd_word1` below bit 30 read 0, including bits 28:27 for an MSI head.
- R4: Bits 15:0 of `rd_word2` hold the message data of an MSI head. `rd_word2` reads 0 when the head is a line interrupt or the queue is empty.
- R5: A `pop` pulse removes the head entry, and entries leave in arrival order. A `pop` while the queue is empty changes nothing.
- R6: The MSI target address is loaded 32 bits at a time: `cfg_lo_we` writes bits 31:0 and `cfg_hi_we` writes bits 63:32. Both halves reset to 0. A write whose 64-bit address matches the target exactly is queued as an MSI. Any other write is ignored.
- R7: A matching write is queued only when its 32-bit data value is below VEC_COUNT (128 by default). Larger values are ignored.
- R8: The queue holds DEPTH entries (16 by default). An event that finds no free slot is dropped, and `overflow` goes to 1 and stays there until reset.
- R9: When an MSI and a line interrupt arrive in the same cycle, both are queued with the MSI ahead. If only one slot is free, the MSI takes it, the line interrupt is dropped and `overflow` is set.
- R10: `msi_pending` is 1 while any MSI entry is queued. `intx_pending` is 1 while any line-interrupt entry is queued.
- R11: An accepted event becomes visible at the read words and flags one clock after it is presented. A pop in the same cycle as an arrival does not free a slot for that arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lo_we | input | 1 | Load low half of MSI target address from cfg_wdata |
| cfg_hi_we | input | 1 | Load high half of MSI target address from cfg_wdata |
| cfg_wdata | input | 32 | Address half to load |
| intx_evt | input | 1 | Line-interrupt assertion event |
| intx_line | input | 2 | Line number of the event |
| wr_valid | input | 1 | Inbound memory write present |
| wr_addr | input | 64 | Inbound write address |
| wr_data | input | 32 | Inbound write data |
| pop | input | 1 | Retire head entry |
| rd_word1 | output | 32 | Valid, kind and line of head entry |
| rd_word2 | output | 32 | MSI data of head entry |
| intx_pending | output | 1 | At least one line-interrupt entry queued |
| msi_pending | output | 1 | At least one MSI entry queued |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
A pointer or count that drifts from the true occupancy shows up at the read words on the very next cycle. It appears as a valid bit with no pending flag, as a wrong head kind or data, or as entries leaving out of order. A stale target address shows up as a missed or spurious MSI one cycle after the write. The bench compares every output against a queue model on every cycle, so a fault is caught within one clock of the first cycle it affects. Directed cases add the fill-to-full, same-cycle pair and pop-while-empty corners that random traffic reaches only rarely.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL
    } qstate_e;

    typedef struct packed {
        logic        is_msi;
        logic [1:0]  line;
        logic [15:0] data;
    } qent_t;

    localparam int W1_VALID_BIT = 31;
    localparam int W1_KIND_BIT  = 30;
    localparam int W1_LINE_LSB  = 27;

endpackage

// File: rtl/rpq_classify.sv
module rpq_classify
    import rpq_pkg::*;
#(
    parameter int VEC_COUNT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_lo_we,
    input  logic        cfg_hi_we,
    input  logic [31:0] cfg_wdata,
    input  logic        wr_valid,
    input  logic [63:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic        intx_evt,
    input  logic [1:0]  intx_line,
    output logic        msi_hit,
    output qent_t       msi_ent,
    output logic        intx_hit,
    output qent_t       intx_ent
);

    localparam logic [31:0] VEC_LIMIT = 32'(VEC_COUNT);

    logic [31:0] base_lo_q;
    logic [31:0] base_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else begin
            if (cfg_lo_we) base_lo_q <= cfg_wdata;
            if (cfg_hi_we) base_hi_q <= cfg_wdata;
        end
    end

    always_comb begin
        msi_hit         = wr_valid && (wr_addr == {base_hi_q, base_lo_q})
                          && (wr_data < VEC_LIMIT);
        msi_ent.is_msi  = 1'b1;
        msi_ent.line    = 2'b00;
        msi_ent.data    = wr_data[15:0];
        intx_hit        = intx_evt;
        intx_ent.is_msi = 1'b0;
        intx_ent.line   = intx_line;
        intx_ent.data   = 16'h0000;
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lo_we && !cfg_hi_we) |=> $stable({base_hi_q, base_lo_q})); // R6

endmodule

// File: rtl/rpq_store.sv
module rpq_store
    import rpq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_a,
    input  qent_t ent_a,
    input  logic  push_b,
    input  qent_t ent_b,
    input  logic  pop,
    output qent_t head,
    output logic  head_vld,
    output logic  msi_any,
    output logic  intx_any,
    output logic  ovf
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TWO_FREE = CNT_W'(DEPTH - 2);

    qent_t            mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] count_q, count_n;
    logic [CNT_W-1:0] msi_cnt_q, intx_cnt_q;
    qstate_e          state_q, state_n;
    logic             has_room;
    logic             acc_a, acc_b, do_pop, drop;
    logic             ovf_q;

    // occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_n;
    end

    // next state: FIRST_IN, LAST_OUT, FILL_UP, MAKE_ROOM
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            Q_EMPTY:   if (count_n != '0) state_n = Q_PARTIAL;
            Q_PARTIAL: begin
                if (count_n == '0)          state_n = Q_EMPTY;
                else if (count_n == FULL_CNT) state_n = Q_FULL;
            end
            Q_FULL:    if (count_n != FULL_CNT) state_n = Q_PARTIAL;
            default:   state_n = Q_EMPTY;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        unique case (state_q)
            Q_EMPTY:   begin head_vld = 1'b0; has_room = 1'b1; end
            Q_PARTIAL: begin head_vld = 1'b1; has_room = 1'b1; end
            Q_FULL:    begin head_vld = 1'b1; has_room = 1'b0; end
            default:   begin head_vld = 1'b0; has_room = 1'b0; end
        endcase
    end

    assign head = mem[rptr_q];

    always_comb begin
        acc_a   = push_a && has_room;
        acc_b   = push_b && (acc_a ? (count_q <= TWO_FREE) : has_room);
        drop    = (push_a && !acc_a) || (push_b && !acc_b);
        do_pop  = pop && head_vld;
        count_n = count_q + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (acc_a) mem[wptr_q] <= ent_a;
        if (acc_b) mem[acc_a ? wptr_q + PTR_W'(1) : wptr_q] <= ent_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            count_q    <= '0;
            msi_cnt_q  <= '0;
            intx_cnt_q <= '0;
            ovf_q      <= 1'b0;
        end else begin
            wptr_q     <= wptr_q + PTR_W'(acc_a) + PTR_W'(acc_b);
            rptr_q     <= rptr_q + PTR_W'(do_pop);
            count_q    <= count_n;
            msi_cnt_q  <= msi_cnt_q + CNT_W'(acc_a) - CNT_W'(do_pop && head.is_msi);
            intx_cnt_q <= intx_cnt_q + CNT_W'(acc_b) - CNT_W'(do_pop && !head.is_msi);
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign msi_any  = (msi_cnt_q != '0);
    assign intx_any = (intx_cnt_q != '0);
    assign ovf      = ovf_q;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && !pop) |=> (state_q == Q_FULL)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R8
    AST_EMPTY_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY) == (msi_cnt_q == '0 && intx_cnt_q == '0)); // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && (push_a || push_b)) |=> ovf_q); // R11

endmodule

// File: rtl/rp_irq_msg_queue.sv
module rp_irq_msg_queue
    import rpq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int VEC_COUNT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_lo_we,
    input  logic        cfg_hi_we,
    input  logic [31:0] cfg_wdata,
    input  logic        intx_evt,
    input  logic [1:0]  intx_line,
    input  logic        wr_valid,
    input  logic [63:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic        pop,
    output logic [31:0] rd_word1,
    output logic [31:0] rd_word2,
    output logic        intx_pending,
    output logic        msi_pending,
    output logic        overflow
);

    logic  msi_hit, intx_hit, head_vld;
    qent_t msi_ent, intx_ent, head;

    rpq_classify #(.VEC_COUNT(VEC_COUNT)) u_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lo_we (cfg_lo_we),
        .cfg_hi_we (cfg_hi_we),
        .cfg_wdata (cfg_wdata),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .intx_evt  (intx_evt),
        .intx_line (intx_line),
        .msi_hit   (msi_hit),
        .msi_ent   (msi_ent),
        .intx_hit  (intx_hit),
        .intx_ent  (intx_ent)
    );

    rpq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_a   (msi_hit),
        .ent_a    (msi_ent),
        .push_b   (intx_hit),
        .ent_b    (intx_ent),
        .pop      (pop),
        .head     (head),
        .head_vld (head_vld),
        .msi_any  (msi_pending),
        .intx_any (intx_pending),
        .ovf      (overflow)
    );

    always_comb begin
        rd_word1 = '0;
        rd_word2 = '0;
        if (head_vld) begin
            rd_word1[W1_VALID_BIT] = 1'b1;
            rd_word1[W1_KIND_BIT]  = head.is_msi;
            if (head.is_msi) rd_word2[15:0] = head.data;
            else             rd_word1[W1_LINE_LSB +: 2] = head.line;
        end
    end

    AST_IDLE_WORD2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word1[W1_VALID_BIT] |-> (rd_word2 == 32'h0)); // R4
    AST_VALID_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word1[W1_VALID_BIT] == (intx_pending || msi_pending)); // R1
    AST_KIND_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word1[W1_VALID_BIT] && rd_word1[W1_KIND_BIT]) |-> msi_pending); // R2

endmodule

// File: tb/tb_rp_irq_msg_queue.sv
`timescale 1ns/1ps
module tb_rp_irq_msg_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_lo_we, cfg_hi_we;
    logic [31:0] cfg_wdata;
    logic        intx_evt;
    logic [1:0]  intx_line;
    logic        wr_valid;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic        pop;
    logic [31:0] rd_word1, rd_word2;
    logic        intx_pending, msi_pending, overflow;

    int    n_run  = 0;
    int    n_fail = 0;
    string ctx    = "";

    logic [18:0] mq[$];
    logic [31:0] mb_lo, mb_hi;
    logic        m_ovf;

    always #2.5 clk = ~clk;

    rp_irq_msg_queue dut (
        .clk(clk), .rst_n(rst_n), .cfg_lo_we(cfg_lo_we), .cfg_hi_we(cfg_hi_we),
        .cfg_wdata(cfg_wdata), .intx_evt(intx_evt), .intx_line(intx_line),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .pop(pop),
        .rd_word1(rd_word1), .rd_word2(rd_word2), .intx_pending(intx_pending),
        .msi_pending(msi_pending), .overflow(overflow)
    );

    function automatic logic [31:0] exp_w1();
        logic [31:0] w = '0;
        if (mq.size() != 0) begin
            w[31] = 1'b1;
            w[30] = mq[0][18];
            if (!mq[0][18]) w[28:27] = mq[0][17:16];
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_w2();
        if (mq.size() != 0 && mq[0][18]) return {16'h0, mq[0][15:0]};
        return 32'h0;
    endfunction

    function automatic logic exp_pend(input logic want_msi);
        foreach (mq[i]) if (mq[i][18] == want_msi) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e1 = exp_w1();
        chk("R1", {31'h0, rd_word1[31]}, {31'h0, e1[31]});
        chk("R2", {31'h0, rd_word1[30]}, {31'h0, e1[30]});
        chk("R3", {2'b0, rd_word1[29:0]}, {2'b0, e1[29:0]});
        chk("R4", rd_word2, exp_w2());
        chk("R10", {30'h0, msi_pending, intx_pending}, {30'h0, exp_pend(1'b1), exp_pend(1'b0)});
        chk("R8", {31'h0, overflow}, {31'h0, m_ovf});
    endtask

    task automatic model_step();
        int   c    = mq.size();
        int   room = 16 - c;
        logic hit  = wr_valid && (wr_addr == {mb_hi, mb_lo}) && (wr_data < 32'd128);
        if (hit) begin
            if (room > 0) begin mq.push_back({1'b1, 2'b00, wr_data[15:0]}); room--; end
            else m_ovf = 1'b1;
        end
        if (intx_evt) begin
            if (room > 0) mq.push_back({1'b0, intx_line, 16'h0});
            else m_ovf = 1'b1;
        end
        if (pop && c > 0) void'(mq.pop_front());
        if (cfg_lo_we) mb_lo = cfg_wdata;
        if (cfg_hi_we) mb_hi = cfg_wdata;
    endtask

    task automatic idle_inputs();
        cfg_lo_we = 0; cfg_hi_we = 0; cfg_wdata = '0; intx_evt = 0; intx_line = 0;
        wr_valid = 0; wr_addr = '0; wr_data = '0; pop = 0;
    endtask

    // apply the current inputs for one clock, then compare after the edge
    task automatic cycle();
        model_step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        mq.delete(); mb_lo = '0; mb_hi = '0; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        ctx = "R1 reset";
        compare_all();
        rst_n = 1'b1;
    endtask

    task automatic send_msi(input logic [63:0] a, input logic [31:0] d);
        wr_valid = 1; wr_addr = a; wr_data = d; cycle();
    endtask

    task automatic send_intx(input logic [1:0] l);
        intx_evt = 1; intx_line = l; cycle();
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) begin pop = 1; cycle(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        ctx = "R6 base match";
        cfg_lo_we = 1; cfg_wdata = 32'h0000_2000; cycle();
        cfg_hi_we = 1; cfg_wdata = 32'h0000_0001; cycle();
        send_msi(64'h1_0000_2000, 32'd5);
        send_msi(64'h0_0000_2000, 32'd6);
        send_msi(64'h1_0000_2004, 32'd7);

        ctx = "R7 vector range";
        send_msi(64'h1_0000_2000, 32'd128);
        send_msi(64'h1_0000_2000, 32'd127);
        send_msi(64'h1_0000_2000, 32'h0001_0003);

        ctx = "R5 order and pop";
        send_intx(2'd2);
        send_intx(2'd3);
        drain();
        pop = 1; cycle();

        ctx = "R9 pair with room";
        wr_valid = 1; wr_addr = 64'h1_0000_2000; wr_data = 32'd9;
        intx_evt = 1; intx_line = 2'd1; cycle();
        pop = 1; cycle();
        pop = 1; cycle();

        ctx = "R2 random";
        for (int ph = 0; ph < 3; ph++) begin
            for (int k = 0; k < 1500; k++) begin
                int r = $urandom % 10;
                intx_evt  = ($urandom % 3) == 0;
                intx_line = 2'($urandom);
                wr_valid  = ($urandom % 2) == 0;
                wr_data   = $urandom % 150;
                if (r < 6)      wr_addr = {mb_hi, mb_lo};
                else if (r < 8) wr_addr = {mb_hi, mb_lo} ^ (64'h1 << ($urandom % 64));
                else            wr_addr = {$urandom, $urandom};
                pop = ($urandom % 10) < (ph == 0 ? 6 : (ph == 1 ? 4 : 9));
                if (($urandom % 100) == 0) begin
                    cfg_lo_we = 1; cfg_wdata = $urandom;
                end
                cycle();
            end
            if (ph == 0) do_reset();
        end

        do_reset();
        ctx = "R8 fill to full";
        for (int i = 0; i < 15; i++) send_intx(2'(i));
        ctx = "R9 pair one slot";
        wr_valid = 1; wr_addr = 64'h0; wr_data = 32'd44;
        intx_evt = 1; intx_line = 2'd3; cycle();
        ctx = "R11 pop with push when full";
        intx_evt = 1; intx_line = 2'd2; pop = 1; cycle();
        send_intx(2'd1);
        ctx = "R5 drain after full";
        drain();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule